// File: doc/BRIEF.md
# Three-Wire Tuner Control Word Receiver

This block takes one synthesizer control word from a three-wire serial link (data, serial clock, enable) and hands it to the tuner's internal registers. All three lines are asynchronous to the system clock. Each goes through a two-flop synchronizer, and edges are found on the synchronized copies. While enable is high, every falling edge of the serial clock shifts one data bit into a shift register, most significant bit first, and advances a pulse counter.

When enable falls, the word is committed only if the frame held exactly the expected number of clock pulses (nineteen by default). Otherwise the frame is dropped and the outputs keep their old values. A committed word drives two outputs: the upper fifteen bits go to the divider scaling factor and the lower four bits go to the band switch outputs. A one-cycle strobe marks each commit. The charge-pump current select output is fixed at the high setting, because this link cannot program it.

Top module: `tw_ctrl_rx`

## Requirements
- R1: Each falling edge of `ser_clk_i` seen while `ser_en_i` is high shifts the current `ser_data_i` bit into the word. The first bit received is the most significant.
- R2: Serial clock edges seen while `ser_en_i` is low have no effect: they change no output and add to no frame.
- R3: A word is committed on the falling edge of `ser_en_i`. After the commit, `scale_o` holds the first 15 bits received, in bits 14 down to 0, and `band_o` holds the last 4 bits, in bits 3 down to 0.
- R4: A commit happens only if exactly 19 serial clock falling edges arrived while enable was high. A frame with fewer or more edges leaves `scale_o` and `band_o` unchanged and raises no strobe.
- R5: The pulse count saturates above 19, so a frame of any length greater than 19 (for example 51) is rejected. The count restarts from zero at every rising edge of enable.
- R6: `upd_o` goes high for exactly one system clock cycle in the cycle where new `scale_o` and `band_o` values first appear. `scale_o` and `band_o` change in no other cycle.
- R7: `cp_high_o` is always 1.
- R8: After reset, `scale_o` and `band_o` are zero and `upd_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial data line |
| ser_clk_i | input | 1 | Serial clock line |
| ser_en_i | input | 1 | Frame enable line |
| scale_o | output | 15 | Latched divider scaling factor |
| band_o | output | 4 | Latched band switch bits |
| cp_high_o | output | 1 | Charge-pump high-current select, fixed at 1 |
| upd_o | output | 1 | One-cycle strobe when a new word is latched |

## Verification
The assertions check on every cycle that the shift register holds still while the synchronized enable is low, that the pulse count never goes past its saturation value, that every strobe follows a frame of exactly the right length and lasts one cycle, and that the latched outputs move only together with the strobe. Only the bench scenarios can show which values end up latched. That covers bit order, the split between scaling factor and band bits, and the rejection of short, long and wrap-length frames at the ports. It also covers clock activity with enable low, which must leave the outputs alone.

// File: rtl/tw_ctrl_pkg.sv
package tw_ctrl_pkg;
  parameter int unsigned SF_W      = 15;
  parameter int unsigned SW_W      = 4;
  parameter int unsigned FRAME_LEN = SF_W + SW_W;
  parameter int unsigned SYNC_W    = 3;
  // index of each line in the synchronizer bus
  parameter int unsigned IDX_DAT   = 0;
  parameter int unsigned IDX_SCK   = 1;
  parameter int unsigned IDX_EN    = 2;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] st1_q, st2_q, prev_q;

  for (genvar g = 0; g < W; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1_q[g]  <= 1'b0;
        st2_q[g]  <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        st1_q[g]  <= async_i[g];
        st2_q[g]  <= st1_q[g];
        prev_q[g] <= st2_q[g];
      end
    end
    assign fall_o[g] = prev_q[g] & ~st2_q[g];
    assign rise_o[g] = ~prev_q[g] & st2_q[g];
  end

  assign sync_o = st2_q;
endmodule

// File: rtl/tw_frame_shift.sv
module tw_frame_shift #(
  parameter int unsigned FRAME_LEN = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_lvl,
  input  logic                 en_rise,
  input  logic                 sck_fall,
  input  logic                 dat,
  output logic [FRAME_LEN-1:0] word_o,
  output logic                 len_ok_o,
  output logic [$clog2(FRAME_LEN+2)-1:0] cnt_o
);
  localparam int unsigned CNT_W   = $clog2(FRAME_LEN + 2);
  localparam int unsigned CNT_SAT = FRAME_LEN + 1;

  logic [FRAME_LEN-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 shift_en, cnt_en;

  always_comb begin
    shift_en = en_lvl & sck_fall;
    cnt_en   = en_rise | shift_en;
    sr_d     = {sr_q[FRAME_LEN-2:0], dat};
    if (en_rise)
      cnt_d = '0;
    else if (cnt_q == CNT_W'(CNT_SAT))
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (shift_en) sr_q  <= sr_d;
      if (cnt_en)   cnt_q <= cnt_d;
    end
  end

  assign word_o   = sr_q;
  assign cnt_o    = cnt_q;
  assign len_ok_o = (cnt_q == CNT_W'(FRAME_LEN));

  // R2: with enable low the shift register holds
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_lvl |=> $stable(sr_q));
  // R5: counter never exceeds its saturation value
  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_SAT));
  // R1: the register moves only on a serial clock fall
  p_shift_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(sr_q));
endmodule

// File: rtl/tw_word_latch.sv
module tw_word_latch #(
  parameter int unsigned SF_W = 15,
  parameter int unsigned SW_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit,
  input  logic [SF_W+SW_W-1:0] word_i,
  output logic [SF_W-1:0]      scale_o,
  output logic [SW_W-1:0]      band_o,
  output logic                 upd_o
);
  logic [SF_W-1:0] scale_q, scale_d;
  logic [SW_W-1:0] band_q, band_d;
  logic            upd_q;

  always_comb begin
    scale_d = word_i[SF_W+SW_W-1:SW_W];
    band_d  = word_i[SW_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q <= '0;
      band_q  <= '0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= commit;
      if (commit) begin
        scale_q <= scale_d;
        band_q  <= band_d;
      end
    end
  end

  assign scale_o = scale_q;
  assign band_o  = band_q;
  assign upd_o   = upd_q;

  // R6: strobe lasts a single cycle
  p_upd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);
  // R6: outputs move only alongside the strobe
  p_out_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> $stable({scale_q, band_q}));
endmodule

// File: rtl/tw_ctrl_rx.sv
module tw_ctrl_rx
  import tw_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_data_i,
  input  logic            ser_clk_i,
  input  logic            ser_en_i,
  output logic [SF_W-1:0] scale_o,
  output logic [SW_W-1:0] band_o,
  output logic            cp_high_o,
  output logic            upd_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 2);

  logic [1:0]           rst_pipe_q;
  logic                 rst_int_n;
  logic [SYNC_W-1:0]    raw, lvl, fall, rise;
  logic [FRAME_LEN-1:0] word;
  logic                 len_ok, commit;
  logic [CNT_W-1:0]     cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  always_comb begin
    raw          = '0;
    raw[IDX_DAT] = ser_data_i;
    raw[IDX_SCK] = ser_clk_i;
    raw[IDX_EN]  = ser_en_i;
  end

  tw_sync #(.W(SYNC_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (raw),
    .sync_o  (lvl),
    .fall_o  (fall),
    .rise_o  (rise)
  );

  tw_frame_shift #(.FRAME_LEN(FRAME_LEN)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en_lvl   (lvl[IDX_EN]),
    .en_rise  (rise[IDX_EN]),
    .sck_fall (fall[IDX_SCK]),
    .dat      (lvl[IDX_DAT]),
    .word_o   (word),
    .len_ok_o (len_ok),
    .cnt_o    (cnt)
  );

  assign commit = fall[IDX_EN] & len_ok;

  tw_word_latch #(.SF_W(SF_W), .SW_W(SW_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .commit  (commit),
    .word_i  (word),
    .scale_o (scale_o),
    .band_o  (band_o),
    .upd_o   (upd_o)
  );

  assign cp_high_o = 1'b1;

  // R4: a strobe follows only a frame of exact length
  p_upd_exact_len_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_o |-> ($past(cnt) == CNT_W'(FRAME_LEN)));
  // R3: a strobe follows an enable fall
  p_upd_after_en_fall_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_o |-> $past(fall[IDX_EN]));
endmodule

// File: tb/sim_tw_ctrl_rx.sv
module sim_tw_ctrl_rx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dat, sck, en;
  logic [14:0] scale;
  logic [3:0]  band;
  logic        cp_high, upd;

  int checks = 0;
  int errors = 0;
  logic [18:0] exp_q[$];
  logic [18:0] cur_word = '0;
  bit          done = 0;

  always #2 clk = ~clk;

  tw_ctrl_rx u0 (
    .clk(clk), .rst_n(rst_n), .ser_data_i(dat), .ser_clk_i(sck),
    .ser_en_i(en), .scale_o(scale), .band_o(band), .cp_high_o(cp_high),
    .upd_o(upd)
  );

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one frame with n serial clock pulses
  task automatic send_frame(input logic [63:0] pat, input int n);
    en = 1'b1; hold(4);
    for (int i = 0; i < n; i++) begin
      dat = pat[n-1-i];
      sck = 1'b1; hold(3);
      sck = 1'b0; hold(3);
    end
    if (n == 19) begin
      exp_q.push_back(pat[18:0]);
      cur_word = pat[18:0];
    end
    en = 1'b0; hold(10);
  endtask

  task automatic idle_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      dat = i[0];
      sck = 1'b1; hold(3);
      sck = 1'b0; hold(3);
    end
    hold(6);
  endtask

  task automatic check_held(input string req);
    chk({scale, band} == cur_word, req, {13'd0, scale, band}, {13'd0, cur_word});
  endtask

  // monitor: compares each strobe with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && upd) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected update", {13'd0, scale, band}, 32'd0);
      end else begin
        logic [18:0] w;
        w = exp_q.pop_front();
        chk(scale == w[18:4], "R3 scale", {17'd0, scale}, {17'd0, w[18:4]});
        chk(band == w[3:0], "R3 band", {28'd0, band}, {28'd0, w[3:0]});
      end
    end
  end

  // R6: strobe length
  logic upd_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && upd && upd_prev) chk(1'b0, "R6 strobe longer than one cycle", 1, 0);
    upd_prev <= upd;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dat = 1'b0; sck = 1'b0; en = 1'b0;
    hold(5);
    rst_n = 1'b1; hold(5);
    // R8 reset state
    chk(scale == 0, "R8 scale reset", {17'd0, scale}, 0);
    chk(band == 0, "R8 band reset", {28'd0, band}, 0);
    chk(upd == 0, "R8 upd reset", {31'd0, upd}, 0);
    chk(cp_high == 1, "R7 cp_high", {31'd0, cp_high}, 1);

    // R1/R3 bit order and field split
    send_frame(64'h5_A5C3, 19); check_held("R1 word after frame");
    send_frame(64'h7_FFF1, 19); check_held("R3 all-ones scale");
    send_frame(64'h0_0008, 19); check_held("R3 band msb");
    send_frame(64'h4_0000, 19); check_held("R1 msb first");

    // R4 short and long frames
    send_frame(64'h1_2345, 18); check_held("R4 short frame ignored");
    send_frame(64'h0AB_CDEF, 20); check_held("R4 long frame ignored");
    send_frame(64'h0, 0);        check_held("R4 empty frame ignored");

    // R5 wrap length 51 must be rejected
    send_frame(64'h0007_1234_5678_9ABC, 51); check_held("R5 51-pulse frame");
    send_frame(64'h2_468A, 19); check_held("R5 count restarts");

    // R2 clock activity while enable low
    idle_pulses(25); check_held("R2 idle pulses");
    idle_pulses(19); check_held("R2 idle 19 pulses");
    send_frame(64'h3_1337, 19); check_held("R2 frame after idle");

    chk(cp_high == 1, "R7 cp_high end", {31'd0, cp_high}, 1);
    chk(exp_q.size() == 0, "R6 all updates seen", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule